// File: doc/BRIEF.md
# Answer-to-Reset Serializer

This block sends a fixed 32-bit answer-to-reset header on a single serial data line. A pulse on the card reset input starts it. The chip select must be low when the pulse arrives, and no nonvolatile write may be in progress. No bus start condition is needed. The header goes out least significant bit first, as bits b1 to b32. The external serial clock sets the pace: each falling edge moves the line to the next bit, so every bit is stable for the following clock-high phase.

The block runs on the system clock. The card reset, chip select and serial clock pins pass through two-flop synchronizers, and their edges are found in the system clock domain. The write-busy flag comes from logic inside the chip and is already synchronous. Raising chip select at any point abandons the header and releases the line. A new reset pulse during an answer starts the answer again from b1. After the last bit the line is released, and further serial clock pulses do nothing until the next reset pulse.

Top module: `atr_serializer`

## Requirements
- R1: After system reset the line is released (`line_oe` = 0) and stays released without a valid reset pulse.
- R2: An answer starts only on a rising edge of `card_reset` while `select_n` is low and `nv_write_busy` is low. A pulse that arrives while selection is high or a write is busy is ignored.
- R3: While `card_reset` stays high after a valid start, the line stays released. Once `card_reset` falls, the line is driven with bit b1 before any serial clock edge.
- R4: The header is the byte sequence 19h, 55h, AAh, 55h, which is the 32-bit word 32'h55AA5519. Bit b(k+1) on the line is bit k of that word, for k = 0..31.
- R5: Each falling edge of `ser_clk` moves the line to the next bit. The driven bit does not change at any other time.
- R6: The falling edge that follows b32 releases the line and returns the block to idle. Later `ser_clk` pulses leave the line released.
- R7: A high level on `select_n` during an answer releases the line within three system clocks. The block stays idle when select goes low again.
- R8: A valid reset pulse during an answer restarts the sequence. The line is released while the pulse is high and resumes at b1 after it.
- R9: `line_bit` is 0 whenever `line_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| select_n | input | 1 | Chip select pin, active low, asynchronous |
| card_reset | input | 1 | Card reset pin, active high pulse, asynchronous |
| ser_clk | input | 1 | External serial clock pin, asynchronous |
| nv_write_busy | input | 1 | High while a nonvolatile write cycle runs (synchronous) |
| line_oe | output | 1 | Drive enable for the serial data pad |
| line_bit | output | 1 | Value driven on the serial data pad |

## Verification
The bench checks every one of the 32 bits at its serial clock high phase. A design that sent the header MSB first, or put the bytes in the wrong order, fails on the first differing bit. It also checks the line before the first clock edge and while the reset pulse is still high. A design that drove b1 too early or too late fails there. The answer is aborted part way, restarted part way, and then clocked past its last bit. A design that kept its index, resumed from the middle, or kept driving after b32 fails these checks. Finally, reset pulses are sent while selection is high and while a write is busy, so a design that ignored either qualifier starts driving where it must not.

// File: rtl/atr_pkg.sv
`timescale 1ns/1ps
package atr_pkg;
  // Sequencer states: waiting, start seen with reset still high, shifting
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } atr_state_e;
endpackage

// File: rtl/atr_sync.sv
`timescale 1ns/1ps
module atr_sync #(
  parameter int              N    = 3,
  parameter logic [N-1:0]    INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_raw,
  output logic [N-1:0] out_lvl
);
  logic [N-1:0] meta_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g]  <= INIT[g];
        out_lvl[g] <= INIT[g];
      end else begin
        meta_q[g]  <= in_raw[g];
        out_lvl[g] <= meta_q[g];
      end
    end
  end
endmodule

// File: rtl/atr_edge.sv
`timescale 1ns/1ps
module atr_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  if (RISING) begin : g_rise
    assign pulse = lvl & ~prev_q;
  end else begin : g_fall
    assign pulse = ~lvl & prev_q;
  end
endmodule

// File: rtl/atr_sequencer.sv
`timescale 1ns/1ps
module atr_sequencer
  import atr_pkg::*;
#(
  parameter int BITS = 32,
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,      // synchronized deselect
  input  logic            start_req,  // qualified reset rising edge
  input  logic            hold,       // synchronized reset level
  input  logic            step,       // serial clock falling edge
  output atr_state_e      state,
  output logic [IDXW-1:0] bit_idx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BITS - 1);

  atr_state_e      state_d;
  logic [IDXW-1:0] idx_d;
  logic            upd_en;

  always_comb begin
    state_d = state;
    idx_d   = bit_idx;
    if (abort) begin
      state_d = ST_IDLE;
      idx_d   = '0;
    end else if (start_req) begin
      state_d = ST_ARMED;
      idx_d   = '0;
    end else begin
      unique case (state)
        ST_ARMED: if (!hold) state_d = ST_SEND;
        ST_SEND: begin
          if (step) begin
            if (bit_idx == LAST_IDX) begin
              state_d = ST_IDLE;
              idx_d   = '0;
            end else begin
              idx_d = bit_idx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign upd_en = (state_d != state) || (idx_d != bit_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
    end else if (upd_en) begin
      state   <= state_d;
      bit_idx <= idx_d;
    end
  end
endmodule

// File: rtl/atr_header_mux.sv
`timescale 1ns/1ps
module atr_header_mux
  import atr_pkg::*;
#(
  parameter int             BITS   = 32,
  parameter logic [BITS-1:0] HEADER = 32'h55AA5519,
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  atr_state_e      state,
  input  logic [IDXW-1:0] bit_idx,
  output logic            drive,
  output logic            value
);
  assign drive = (state == ST_SEND);
  assign value = drive & HEADER[bit_idx];
endmodule

// File: rtl/atr_serializer.sv
`timescale 1ns/1ps
module atr_serializer
  import atr_pkg::*;
#(
  parameter int             BITS   = 32,
  parameter logic [BITS-1:0] HEADER = 32'h55AA5519
) (
  input  logic clk,
  input  logic rst_n,
  input  logic select_n,
  input  logic card_reset,
  input  logic ser_clk,
  input  logic nv_write_busy,
  output logic line_oe,
  output logic line_bit
);
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1;

  // Synchronized pins: [2] select_n (idles high), [1] card_reset, [0] ser_clk
  logic [2:0]      pins_s;
  logic            sel_s;
  logic            crst_s;
  logic            sclk_s;
  logic            crst_rise;
  logic            scl_fall;
  logic            start_req;
  atr_state_e      state;
  logic [IDXW-1:0] bit_idx;

  atr_sync #(.N(3), .INIT(3'b100)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_raw ({select_n, card_reset, ser_clk}),
    .out_lvl(pins_s)
  );

  assign sel_s  = pins_s[2];
  assign crst_s = pins_s[1];
  assign sclk_s = pins_s[0];

  atr_edge #(.RISING(1'b1)) u_crst_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (crst_s),
    .pulse(crst_rise)
  );

  atr_edge #(.RISING(1'b0)) u_sclk_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sclk_s),
    .pulse(scl_fall)
  );

  assign start_req = crst_rise & ~sel_s & ~nv_write_busy;

  atr_sequencer #(.BITS(BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (sel_s),
    .start_req(start_req),
    .hold     (crst_s),
    .step     (scl_fall),
    .state    (state),
    .bit_idx  (bit_idx)
  );

  atr_header_mux #(.BITS(BITS), .HEADER(HEADER)) u_mux (
    .state  (state),
    .bit_idx(bit_idx),
    .drive  (line_oe),
    .value  (line_bit)
  );
endmodule

// File: rtl/atr_checker.sv
`timescale 1ns/1ps
module atr_checker #(
  parameter int             BITS   = 32,
  parameter logic [BITS-1:0] HEADER = 32'h55AA5519,
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_s,
  input logic            start_req,
  input logic            scl_fall,
  input logic [IDXW-1:0] bit_idx,
  input logic            line_oe,
  input logic            line_bit
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BITS - 1);

  assert_quiet_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> !line_bit);

  assert_deselect_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !line_oe);

  assert_bit_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && $past(line_oe) && !$past(scl_fall)) |-> (line_bit == $past(line_bit)));

  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> (bit_idx == '0 && line_bit == HEADER[0]));

  assert_release_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(line_oe) && !$past(sel_s) && !$past(start_req)) |-> ($past(bit_idx) == LAST_IDX));
endmodule

bind atr_serializer atr_checker #(.BITS(BITS), .HEADER(HEADER)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_s    (sel_s),
  .start_req(start_req),
  .scl_fall (scl_fall),
  .bit_idx  (bit_idx),
  .line_oe  (line_oe),
  .line_bit (line_bit)
);

// File: tb/atr_serializer_test.sv
`timescale 1ns/1ps
module atr_serializer_test;
  typedef struct {
    logic  oe;
    logic  bt;
    string tag;
  } exp_t;

  localparam logic [31:0] HDR = {8'h55, 8'hAA, 8'h55, 8'h19};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic select_n = 1'b1;
  logic card_reset = 1'b0;
  logic ser_clk = 1'b0;
  logic nv_write_busy = 1'b0;
  logic line_oe;
  logic line_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];
  event mon_ev;

  always #10 clk = ~clk;  // 50 MHz

  atr_serializer uut (
    .clk(clk), .rst_n(rst_n), .select_n(select_n), .card_reset(card_reset),
    .ser_clk(ser_clk), .nv_write_busy(nv_write_busy),
    .line_oe(line_oe), .line_bit(line_bit)
  );

  // Monitor: pops expected items and compares them with the pads
  always @(mon_ev) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (line_oe !== e.oe || line_bit !== e.bt) begin
        errors++;
        $display("FAIL %s: oe=%0b bit=%0b expected oe=%0b bit=%0b",
                 e.tag, line_oe, line_bit, e.oe, e.bt);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_line(input logic oe, input logic bt, input string tag);
    exp_t e;
    e.oe = oe; e.bt = bt; e.tag = tag;
    q.push_back(e);
    -> mon_ev;
    #1;
  endtask

  task automatic reset_pulse(input string tag, input logic armed);
    card_reset = 1'b1;
    wait_clk(5);
    if (armed) expect_line(1'b0, 1'b0, {tag, " released while reset high"});
    card_reset = 1'b0;
    wait_clk(6);
  endtask

  task automatic scl_pulse(input logic oe, input logic bt, input string tag);
    ser_clk = 1'b1;
    wait_clk(4);
    expect_line(oe, bt, tag);
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(8);
  endtask

  task automatic send_bits(input int first, input int count, input string tag);
    for (int k = first; k < first + count; k++)
      scl_pulse(1'b1, HDR[k], $sformatf("%s b%0d", tag, k + 1));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: oe=%0b bit=%0b expected completion", line_oe, line_bit);
      summary();
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    expect_line(1'b0, 1'b0, "R1 reset state");
    select_n = 1'b0;
    wait_clk(5);
    scl_pulse(1'b0, 1'b0, "R1 idle ignores clock");

    // Full answer
    reset_pulse("R3", 1'b1);
    expect_line(1'b1, HDR[0], "R3 b1 before first clock");
    send_bits(0, 32, "R4 R5");
    expect_line(1'b0, 1'b0, "R6 released after b32");
    scl_pulse(1'b0, 1'b0, "R6 extra clock ignored");
    scl_pulse(1'b0, 1'b0, "R6 extra clock ignored");

    // Start blocked by busy write
    nv_write_busy = 1'b1;
    reset_pulse("R2 busy", 1'b0);
    nv_write_busy = 1'b0;
    expect_line(1'b0, 1'b0, "R2 busy start ignored");
    scl_pulse(1'b0, 1'b0, "R2 busy start ignored clock");

    // Start blocked by deselect
    select_n = 1'b1;
    wait_clk(5);
    reset_pulse("R2 deselected", 1'b0);
    select_n = 1'b0;
    wait_clk(5);
    expect_line(1'b0, 1'b0, "R2 deselected start ignored");
    scl_pulse(1'b0, 1'b0, "R2 deselected start ignored clock");

    // Abort part way
    reset_pulse("R7 setup", 1'b1);
    send_bits(0, 5, "R7 prefix");
    select_n = 1'b1;
    wait_clk(4);
    expect_line(1'b0, 1'b0, "R7 deselect releases");
    select_n = 1'b0;
    wait_clk(5);
    expect_line(1'b0, 1'b0, "R7 stays idle after reselect");
    scl_pulse(1'b0, 1'b0, "R7 clock after abort ignored");

    // Restart part way
    reset_pulse("R8 setup", 1'b1);
    send_bits(0, 10, "R8 prefix");
    reset_pulse("R8 restart", 1'b1);
    expect_line(1'b1, HDR[0], "R8 restart at b1");
    send_bits(0, 32, "R8 R4");
    expect_line(1'b0, 1'b0, "R8 R6 released after restart");

    done = 1'b1;
    summary();
  end
endmodule